// File: doc/BRIEF.md
# Programmable Memory Aperture Window

This block holds the two configuration registers that place a memory aperture in a 32-bit address space, and it decodes incoming addresses against that aperture. A 6-bit size code sets the aperture from 4 MB up to 256 MB. Each bit of that code decides whether one base-address bit, bits 22 to 27, can be written or is held at zero. Software writes the size code first. A later sizing pass that writes all-ones to the base register then reads back only the bits that the chosen size leaves free, so the read-back shows the size of the range the aperture needs.

The configuration port takes a byte address (the dword is picked by address bits 7:2), 32-bit write data, four byte enables and a write strobe. Read data comes back from the same cycle's address with no wait. Apart from the port, the block takes a 32-bit memory address and returns, with no clock in between, a hit flag and the offset of that address within the aperture.

Top module: `apr_window`

## Requirements
- R1: After reset the size code is 000000 and every base bit reads 0. This gives a 256 MB aperture at address 0.
- R2: The size code sits in bits 5:0 of byte lane 0 of the dword at byte offset B4h. It is written through byte enable bit 0. Bits 31:6 of that dword always read 0. Any code is stored as written, legal or not.
- R3: The base register is the dword at byte offset 10h. Its bits 31:28 can always be written, and its bits 21:0 always read 0.
- R4: Base bit 22+i, for i from 0 to 5, takes writes and reads back its stored value only while size bit i is 1. While size bit i is 0, it reads 0 and writes to it have no effect.
- R5: A base bit that was forced to zero by clearing its size bit still reads 0 after the size bit is set again. It only comes back to 1 through a new write.
- R6: The hit flag is 1 exactly when address bits 31:22 match the base bits 31:22 in every position of the mask {1111, size code}. For the legal codes 111111, 111110, 111100, 111000, 110000, 100000 and 000000, this gives apertures of 4, 8, 16, 32, 64, 128 and 256 MB.
- R7: The offset output equals the memory address with every bit of the mask {1111, size code}, placed at bits 31:22, cleared.
- R8: A register byte changes only on a rising edge at which the write strobe is 1, the byte's enable is 1 and the address selects that register's dword.
- R9: Every dword other than 10h and B4h reads 0, and writes to it change neither register.
- R10: For an illegal size code, the writable base bits and the hit compare follow the code bit by bit. A 0 bit in the code makes that address bit a don't-care.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_we | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, same cycle |
| mem_addr | input | 32 | Memory address to decode |
| apr_hit | output | 1 | Address lies inside the aperture |
| apr_offset | output | 32 | Offset of mem_addr within the aperture |

## Verification
Register reads and the hit/offset decode are combinational, so they are due in the same cycle that their address is driven. A configuration write takes effect at the first rising edge at which the strobe is high. The bench drives every input just after a falling edge and samples one nanosecond later, which is always after the edge that completed the previous write. When a size bit is cleared, the base bit it guards reads 0 at once, and the stored copy is wiped at the next edge. The no-resurface check therefore sets the size bit again only after a full cycle has passed.

// File: rtl/apr_pkg.sv
package apr_pkg;
    localparam int APR_ADDR_W    = 32;
    localparam int APR_CFG_AW    = 8;
    localparam int APR_LSB_DEF   = 22;
    localparam int APR_SIZE_BITS = 6;

    // True when a byte address selects the dword that holds byte offset ofs.
    function automatic logic dword_sel(input logic [APR_CFG_AW-1:0] addr,
                                       input logic [APR_CFG_AW-1:0] ofs);
        return addr[APR_CFG_AW-1:2] == ofs[APR_CFG_AW-1:2];
    endfunction
endpackage

// File: rtl/apr_size_reg.sv
module apr_size_reg
    import apr_pkg::*;
#(
    parameter int          ADDR_W    = APR_ADDR_W,
    parameter int          CFG_AW    = APR_CFG_AW,
    parameter int          SIZE_BITS = APR_SIZE_BITS,
    parameter logic [7:0]  SIZE_OFS  = 8'hB4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic                  cfg_we,
    input  logic [ADDR_W/8-1:0]   cfg_be,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    output logic [SIZE_BITS-1:0]  size_code
);
    localparam int LANE = int'(SIZE_OFS[1:0]);

    logic wr_en;
    assign wr_en = cfg_we && cfg_be[LANE] && dword_sel(cfg_addr, SIZE_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            size_code <= '0;
        else if (wr_en)
            size_code <= cfg_wdata[LANE*8 +: SIZE_BITS];
    end
endmodule

// File: rtl/apr_base_reg.sv
module apr_base_reg
    import apr_pkg::*;
#(
    parameter int          ADDR_W    = APR_ADDR_W,
    parameter int          CFG_AW    = APR_CFG_AW,
    parameter int          APR_LSB   = APR_LSB_DEF,
    parameter int          SIZE_BITS = APR_SIZE_BITS,
    parameter logic [7:0]  BASE_OFS  = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic                  cfg_we,
    input  logic [ADDR_W/8-1:0]   cfg_be,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    input  logic [SIZE_BITS-1:0]  size_code,
    output logic [ADDR_W-1:0]     base_raw,
    output logic [ADDR_W-1:0]     base_eff
);
    localparam int GATE_HI = APR_LSB + SIZE_BITS;

    logic wr_sel;
    assign wr_sel = cfg_we && dword_sel(cfg_addr, BASE_OFS);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < APR_LSB) begin : g_zero
            assign base_raw[i] = 1'b0;
            assign base_eff[i] = 1'b0;
        end else if (i < GATE_HI) begin : g_gated
            // Stored copy is wiped while its size bit is 0, so it cannot resurface.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    base_raw[i] <= 1'b0;
                else if (!size_code[i-APR_LSB])
                    base_raw[i] <= 1'b0;
                else if (wr_sel && cfg_be[i/8])
                    base_raw[i] <= cfg_wdata[i];
            end
            assign base_eff[i] = base_raw[i] & size_code[i-APR_LSB];
        end else begin : g_free
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    base_raw[i] <= 1'b0;
                else if (wr_sel && cfg_be[i/8])
                    base_raw[i] <= cfg_wdata[i];
            end
            assign base_eff[i] = base_raw[i];
        end
    end
endmodule

// File: rtl/apr_decode.sv
module apr_decode
    import apr_pkg::*;
#(
    parameter int ADDR_W    = APR_ADDR_W,
    parameter int APR_LSB   = APR_LSB_DEF,
    parameter int SIZE_BITS = APR_SIZE_BITS
) (
    input  logic [ADDR_W-1:0]     mem_addr,
    input  logic [ADDR_W-1:0]     base_eff,
    input  logic [SIZE_BITS-1:0]  size_code,
    output logic                  apr_hit,
    output logic [ADDR_W-1:0]     apr_offset
);
    localparam int HI_W  = ADDR_W - APR_LSB;
    localparam int FIX_W = HI_W - SIZE_BITS;

    logic [HI_W-1:0] cmp_mask;
    logic [HI_W-1:0] diff;

    assign cmp_mask   = {{FIX_W{1'b1}}, size_code};
    assign diff       = mem_addr[ADDR_W-1:APR_LSB] ^ base_eff[ADDR_W-1:APR_LSB];
    assign apr_hit    = (diff & cmp_mask) == '0;
    assign apr_offset = mem_addr & ~{cmp_mask, {APR_LSB{1'b0}}};
endmodule

// File: rtl/apr_window.sv
module apr_window
    import apr_pkg::*;
#(
    parameter int          ADDR_W    = APR_ADDR_W,
    parameter int          CFG_AW    = APR_CFG_AW,
    parameter int          APR_LSB   = APR_LSB_DEF,
    parameter int          SIZE_BITS = APR_SIZE_BITS,
    parameter logic [7:0]  SIZE_OFS  = 8'hB4,
    parameter logic [7:0]  BASE_OFS  = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cfg_addr,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [31:0]        mem_addr,
    output logic               apr_hit,
    output logic [31:0]        apr_offset
);
    localparam int LANE = int'(SIZE_OFS[1:0]);

    logic [SIZE_BITS-1:0] size_code;
    logic [ADDR_W-1:0]    base_raw;
    logic [ADDR_W-1:0]    base_eff;

    apr_size_reg #(
        .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .SIZE_BITS(SIZE_BITS), .SIZE_OFS(SIZE_OFS)
    ) u_size (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .size_code(size_code)
    );

    apr_base_reg #(
        .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .APR_LSB(APR_LSB),
        .SIZE_BITS(SIZE_BITS), .BASE_OFS(BASE_OFS)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .size_code(size_code),
        .base_raw(base_raw), .base_eff(base_eff)
    );

    apr_decode #(
        .ADDR_W(ADDR_W), .APR_LSB(APR_LSB), .SIZE_BITS(SIZE_BITS)
    ) u_dec (
        .mem_addr(mem_addr), .base_eff(base_eff), .size_code(size_code),
        .apr_hit(apr_hit), .apr_offset(apr_offset)
    );

    always_comb begin
        cfg_rdata = '0;
        if (dword_sel(cfg_addr, BASE_OFS))
            cfg_rdata = base_eff;
        else if (dword_sel(cfg_addr, SIZE_OFS))
            cfg_rdata[LANE*8 +: SIZE_BITS] = size_code;
    end
endmodule

// File: rtl/apr_window_chk.sv
module apr_window_chk #(
    parameter int          ADDR_W    = 32,
    parameter int          CFG_AW    = 8,
    parameter int          APR_LSB   = 22,
    parameter int          SIZE_BITS = 6,
    parameter logic [7:0]  SIZE_OFS  = 8'hB4,
    parameter logic [7:0]  BASE_OFS  = 8'h10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CFG_AW-1:0]     cfg_addr,
    input logic                  cfg_we,
    input logic [ADDR_W-1:0]     cfg_rdata,
    input logic [SIZE_BITS-1:0]  size_code,
    input logic [ADDR_W-1:0]     base_raw,
    input logic [ADDR_W-1:0]     base_eff,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic                  apr_hit,
    input logic [ADDR_W-1:0]     apr_offset
);
    localparam int LANE = int'(SIZE_OFS[1:0]);
    localparam logic [ADDR_W-1:0] SIZE_FIELD = ADDR_W'((2**SIZE_BITS - 1) << (LANE*8));

    logic on_base, on_size;
    assign on_base = cfg_addr[CFG_AW-1:2] == BASE_OFS[CFG_AW-1:2];
    assign on_size = cfg_addr[CFG_AW-1:2] == SIZE_OFS[CFG_AW-1:2];

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (size_code == '0 && base_raw == '0));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        on_size |-> ((cfg_rdata & ~SIZE_FIELD) == '0));

    a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        on_base |-> (cfg_rdata[APR_LSB-1:0] == '0));

    a_r4_forced_read: assert property (@(posedge clk) disable iff (!rst_n)
        on_base |-> ((cfg_rdata[APR_LSB +: SIZE_BITS] & ~size_code) == '0));

    a_r5_wiped: assert property (@(posedge clk) disable iff (!rst_n)
        (base_raw[APR_LSB +: SIZE_BITS] & ~$past(size_code)) == '0);

    a_r6_base_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[ADDR_W-1:APR_LSB] == base_eff[ADDR_W-1:APR_LSB]) |-> apr_hit);

    a_r7_offset_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
        apr_hit |-> ((base_eff | apr_offset) == mem_addr));

    a_r8_hold_size: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(size_code));

    a_r8_hold_base: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(base_eff));
endmodule

bind apr_window apr_window_chk #(
    .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .APR_LSB(APR_LSB),
    .SIZE_BITS(SIZE_BITS), .SIZE_OFS(SIZE_OFS), .BASE_OFS(BASE_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_rdata(cfg_rdata), .size_code(size_code), .base_raw(base_raw),
    .base_eff(base_eff), .mem_addr(mem_addr), .apr_hit(apr_hit),
    .apr_offset(apr_offset)
);

// File: tb/tb_apr_window.sv
`timescale 1ns/1ps
module tb_apr_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] mem_addr = '0;
    logic        apr_hit;
    logic [31:0] apr_offset;

    int total = 0;
    int fails = 0;

    localparam logic [7:0] SZ = 8'hB4;
    localparam logic [7:0] BS = 8'h10;

    always #2.5 clk = ~clk;

    apr_window dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .apr_hit(apr_hit), .apr_offset(apr_offset)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Expected hit/offset from the range [base, base+size).
    task automatic probe(input string req, input logic [31:0] a,
                         input logic [31:0] base, input logic [63:0] sz);
        logic [63:0] a64;
        logic        exp_hit;
        logic [31:0] exp_off;
        a64 = {32'd0, a};
        exp_hit = (a64 >= {32'd0, base}) && (a64 < {32'd0, base} + sz);
        exp_off = exp_hit ? (a - base) : (a & 32'(sz - 64'd1));
        @(negedge clk);
        mem_addr = a;
        #1;
        check({req, " hit"}, {31'd0, apr_hit}, {31'd0, exp_hit});
        check({req, " offset"}, apr_offset, exp_off);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(SZ, d); check("R1 size reset", d, 32'h0);
        rd(BS, d); check("R1 base reset", d, 32'h0);
        probe("R1 256MB at 0", 32'h0FFF_FFFF, 32'h0, 64'h1000_0000);
        probe("R1 256MB miss", 32'h1000_0000, 32'h0, 64'h1000_0000);

        // R2/R3/R4/R6/R7: sweep all legal codes
        for (int k = 0; k <= 6; k++) begin
            logic [5:0]  code;
            logic [31:0] expb, b;
            logic [63:0] sz;
            code = (k == 6) ? 6'h00 : 6'(6'h3F << k);
            sz   = 64'h40_0000 << k;
            wr(SZ, 32'hFFFF_FF00 | {26'd0, code}, 4'b0001);
            rd(SZ, d); check("R2 size readback", d, {26'd0, code});
            wr(BS, 32'hFFFF_FFFF, 4'hF);
            expb = {4'hF, code, 22'd0};
            rd(BS, d); check("R3 R4 base all-ones readback", d, expb);
            b = d;
            probe("R6 R7 base edge", b, b, sz);
            probe("R6 R7 top edge", b + 32'(sz) - 1, b, sz);
            probe("R6 below base", b - 1, b, sz);
            // mid-range base
            wr(BS, 32'h5A5A_5A5A, 4'hF);
            expb = 32'h5A5A_5A5A & {4'hF, code, 22'd0};
            rd(BS, d); check("R4 patterned base", d, expb);
            probe("R6 R7 low edge", expb, expb, sz);
            probe("R6 R7 high edge", expb + 32'(sz) - 1, expb, sz);
            probe("R6 past end", expb + 32'(sz), expb, sz);
            probe("R6 below start", expb - 1, expb, sz);
        end

        // R2: reserved bits and other lanes read zero
        wr(SZ, 32'hFFFF_FFFF, 4'hF);
        rd(SZ, d); check("R2 reserved zero", d, 32'h0000_003F);
        wr(SZ, 32'h0000_0000, 4'b1110);
        rd(SZ, d); check("R2 lane0 disabled keeps code", d, 32'h0000_003F);

        // R8: byte enables and strobe
        wr(BS, 32'hFFFF_FFFF, 4'hF);
        wr(BS, 32'h0000_0000, 4'b0111);
        rd(BS, d); check("R8 top byte kept", d, 32'hFF00_0000);
        @(negedge clk);
        cfg_addr = BS; cfg_wdata = 32'h0; cfg_be = 4'hF; cfg_we = 1'b0;
        @(negedge clk); cfg_be = '0;
        rd(BS, d); check("R8 no strobe no write", d, 32'hFF00_0000);

        // R9: unmapped dword
        wr(8'h20, 32'hFFFF_FFFF, 4'hF);
        rd(8'h20, d); check("R9 unmapped reads 0", d, 32'h0);
        rd(BS, d);    check("R9 base untouched", d, 32'hFF00_0000);
        rd(SZ, d);    check("R9 size untouched", d, 32'h0000_003F);

        // R5: no resurfacing
        wr(BS, 32'hFFFF_FFFF, 4'hF);
        rd(BS, d); check("R5 setup", d, 32'hFFC0_0000);
        wr(SZ, 32'h0, 4'b0001);
        rd(BS, d); check("R5 forced to zero", d, 32'hF000_0000);
        @(negedge clk);
        wr(SZ, 32'h3F, 4'b0001);
        rd(BS, d); check("R5 no resurface", d, 32'hF000_0000);

        // R10: illegal code 010101 applied bitwise
        wr(SZ, 32'h15, 4'b0001);
        rd(SZ, d); check("R10 illegal code stored", d, 32'h15);
        wr(BS, 32'hFFFF_FFFF, 4'hF);
        rd(BS, d); check("R10 base bitwise", d, 32'hF540_0000);
        @(negedge clk); mem_addr = 32'hF540_0000 | 32'h0280_0000 | 32'h0012_3456;
        #1 check("R10 dont-care bits hit", {31'd0, apr_hit}, 32'd1);
        check("R10 offset keeps dont-care bits", apr_offset, 32'h0292_3456);
        @(negedge clk); mem_addr = 32'hF540_0000 ^ 32'h0100_0000;
        #1 check("R10 masked bit miss", {31'd0, apr_hit}, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule